// File: doc/BRIEF.md
# Machine clock source controller

This block decides which of three clock sources drives the machine clock: the main oscillator, a multiplied PLL output, or a slow sub-oscillator. Software writes a configuration word with two selects, a ratio field and a wait-length field. The controller keeps that word in registers, works out which source is wanted and steps through a fixed transition graph to reach it. A move onto the main oscillator or onto the PLL finishes when a stabilisation counter runs out. A move between two running clocks finishes on a one-cycle synchronisation pulse that the clock generator sends for that pair of clocks.

The outputs report the source in use, the multiplier code latched when the PLL was entered, two status flags that change only when a transition completes, and a flag that refuses a sub-to-PLL request made with a wait length that is too short. A request for the sub-clock overrides the main/PLL choice. A write that arrives while a transition is in progress is kept, and it is acted on once that transition has finished.

Top module: `ckmode_ctrl`

## Requirements
- R1: After reset the source output is main (code 0), both status flags are 1, the ratio output is 0 and the error flag is 0.
- R2: When cfg_sub_off=0 the sub-clock is the wanted source whatever cfg_pll_off holds. From main, this request waits for a main/sub synchronisation pulse and never starts a PLL wait.
- R3: In main mode, writing cfg_pll_off=0 (with cfg_sub_off=1) starts a wait of 2^(WAIT_BASE_LOG2+cfg_wait_sel) cycles. The source output reads PLL (code 1) from the (N+1)-th clock edge after the edge that captured the write.
- R4: On each PLL entry the ratio output takes cfg_ratio[2] ? 4 : {0,cfg_ratio[1:0]}. It holds while the PLL stays in use, even if later writes change cfg_ratio.
- R5: In PLL mode, writing cfg_pll_off=1 returns the source to main only on an edge where sync_pll_main is high. The other two sync pulses have no effect.
- R6: In main mode, writing cfg_sub_off=0 moves the source to sub (code 2) on an edge where sync_main_sub is high, and on no other pulse.
- R7: In PLL mode, writing cfg_sub_off=0 moves the source to sub on an edge where sync_pll_sub is high, and on no other pulse.
- R8: In sub mode, writing cfg_sub_off=1 with cfg_pll_off=1 starts a main-oscillator wait of the same length rule as R3. The source reads main N+1 edges after the write.
- R9: In sub mode, a request for the PLL (cfg_sub_off=1, cfg_pll_off=0) is accepted only when cfg_wait_sel is 2 or 3. It then enters the PLL after the main-oscillator wait. With cfg_wait_sel of 0 or 1 the source stays sub and wait_err_o is 1 one edge after the write, for as long as that request stands.
- R10: stat_no_pll_o is 0 exactly while the PLL is in use, and stat_no_sub_o is 0 exactly while the sub-clock is in use. Neither changes during a wait or a synchronisation hold.
- R11: Writes made during a wait or a synchronisation hold are latched. The current transition completes first, and then the latched selects are evaluated.
- R12: The wait counter reloads at the start of every wait, so back-to-back waits with the same cfg_wait_sel last the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_pll_off | input | 1 | 1 = main oscillator, 0 = PLL |
| cfg_sub_off | input | 1 | 1 = fast clock, 0 = sub-clock (overrides) |
| cfg_ratio | input | 3 | PLL ratio select; bit 2 picks the extra ratio |
| cfg_wait_sel | input | 2 | Stabilisation wait length select |
| sync_pll_main | input | 1 | Sync point pulse, PLL and main clocks |
| sync_main_sub | input | 1 | Sync point pulse, main and sub clocks |
| sync_pll_sub | input | 1 | Sync point pulse, PLL and sub clocks |
| src_o | output | 2 | Source in use: 0 main, 1 PLL, 2 sub |
| ratio_o | output | 3 | Multiplier code latched at PLL entry |
| stat_no_pll_o | output | 1 | 0 while the PLL drives the machine clock |
| stat_no_sub_o | output | 1 | 0 while the sub-clock drives the machine clock |
| wait_err_o | output | 1 | Sub-to-PLL request refused for short wait |

## Verification
A write is captured on one edge and evaluated on the next, so a wait-based change shows on the source output N+1 edges after the capturing edge. The bench samples one nanosecond after edge N and again after edge N+1, and expects the old source first and the new one second. A sync-based change shows on the same edge that samples the pulse, provided the hold state was entered at least one edge earlier. The bench therefore always lets one edge pass after a write before it pulses, and it checks right after the pulse edge. The error flag is registered, so it is checked from the edge after the offending write.

// File: rtl/ckm_pkg.sv
`timescale 1ns/1ps
package ckm_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_MAIN,
        ST_PLL,
        ST_SUB,
        ST_WAIT_PLL,
        ST_HOLD_PM,
        ST_HOLD_MS,
        ST_WAIT_OSC,
        ST_HOLD_PS
    } st_e;

    typedef struct packed {
        logic       pll_off;
        logic       sub_off;
        logic [2:0] ratio;
        logic [1:0] wsel;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{pll_off: 1'b1, sub_off: 1'b1, ratio: 3'd0, wsel: 2'd0};
    localparam logic [2:0] RATIO_EXTRA = 3'd4;

    function automatic logic [2:0] resolve_ratio(input logic [2:0] r);
        return r[2] ? RATIO_EXTRA : {1'b0, r[1:0]};
    endfunction

    function automatic src_e wanted_src(input cfg_t c);
        if (!c.sub_off)      return SRC_SUB;
        else if (!c.pll_off) return SRC_PLL;
        else                 return SRC_MAIN;
    endfunction

    function automatic src_e src_of(input st_e s);
        case (s)
            ST_PLL, ST_HOLD_PM, ST_HOLD_PS: return SRC_PLL;
            ST_SUB, ST_WAIT_OSC:            return SRC_SUB;
            default:                        return SRC_MAIN;
        endcase
    endfunction

    function automatic logic wait_long_enough(input logic [1:0] w);
        return w[1];
    endfunction

endpackage

// File: rtl/ckm_cfg_regs.sv
`timescale 1ns/1ps
module ckm_cfg_regs
    import ckm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  cfg_t wr_cfg,
    output cfg_t cfg_q,
    output src_e want,
    output logic wsel_ok
);
    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= CFG_RESET;
        else if (wr) cfg_q <= wr_cfg;
    end

    always_comb begin
        want    = wanted_src(cfg_q);
        wsel_ok = wait_long_enough(cfg_q.wsel);
    end
endmodule

// File: rtl/ckm_stab_timer.sv
`timescale 1ns/1ps
module ckm_stab_timer #(
    parameter int BASE_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] wsel,
    output logic       done
);
    localparam int CNT_W = BASE_LOG2 + 4;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb reload = (ONE << (BASE_LOG2 + int'(wsel))) - ONE;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= reload;
        else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/ckm_mode_fsm.sv
`timescale 1ns/1ps
module ckm_mode_fsm
    import ckm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_e       want,
    input  logic       wsel_ok,
    input  logic [2:0] ratio_sel,
    input  logic       tmr_done,
    input  logic       sync_pm,
    input  logic       sync_ms,
    input  logic       sync_ps,
    output logic       tmr_load,
    output src_e       src_q,
    output logic [2:0] ratio_q,
    output logic       no_pll_q,
    output logic       no_sub_q,
    output logic       err_q
);
    st_e  st_q, st_n;
    logic dest_pll_q, dest_pll_n;
    logic take_ratio, err_n;

    always_comb begin
        st_n       = st_q;
        dest_pll_n = dest_pll_q;
        tmr_load   = 1'b0;
        take_ratio = 1'b0;
        err_n      = 1'b0;
        case (st_q)
            ST_MAIN: begin
                if (want == SRC_SUB) begin
                    st_n = ST_HOLD_MS;
                end else if (want == SRC_PLL) begin
                    st_n     = ST_WAIT_PLL;
                    tmr_load = 1'b1;
                end
            end
            ST_PLL: begin
                if (want == SRC_SUB)       st_n = ST_HOLD_PS;
                else if (want == SRC_MAIN) st_n = ST_HOLD_PM;
            end
            ST_SUB: begin
                if (want == SRC_MAIN) begin
                    st_n       = ST_WAIT_OSC;
                    tmr_load   = 1'b1;
                    dest_pll_n = 1'b0;
                end else if (want == SRC_PLL) begin
                    if (wsel_ok) begin
                        st_n       = ST_WAIT_OSC;
                        tmr_load   = 1'b1;
                        dest_pll_n = 1'b1;
                    end else begin
                        err_n = 1'b1;
                    end
                end
            end
            ST_WAIT_PLL: begin
                if (tmr_done) begin
                    st_n       = ST_PLL;
                    take_ratio = 1'b1;
                end
            end
            ST_WAIT_OSC: begin
                if (tmr_done) begin
                    st_n       = dest_pll_q ? ST_PLL : ST_MAIN;
                    take_ratio = dest_pll_q;
                end
            end
            ST_HOLD_PM: if (sync_pm) st_n = ST_MAIN;
            ST_HOLD_MS: if (sync_ms) st_n = ST_SUB;
            ST_HOLD_PS: if (sync_ps) st_n = ST_SUB;
            default:    st_n = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_MAIN;
            dest_pll_q <= 1'b0;
            src_q      <= SRC_MAIN;
            ratio_q    <= '0;
            no_pll_q   <= 1'b1;
            no_sub_q   <= 1'b1;
            err_q      <= 1'b0;
        end else begin
            st_q       <= st_n;
            dest_pll_q <= dest_pll_n;
            src_q      <= src_of(st_n);
            no_pll_q   <= (src_of(st_n) != SRC_PLL);
            no_sub_q   <= (src_of(st_n) != SRC_SUB);
            err_q      <= err_n;
            if (take_ratio) ratio_q <= resolve_ratio(ratio_sel);
        end
    end
endmodule

// File: rtl/ckmode_ctrl.sv
`timescale 1ns/1ps
module ckmode_ctrl
    import ckm_pkg::*;
#(
    parameter int WAIT_BASE_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       cfg_pll_off,
    input  logic       cfg_sub_off,
    input  logic [2:0] cfg_ratio,
    input  logic [1:0] cfg_wait_sel,
    input  logic       sync_pll_main,
    input  logic       sync_main_sub,
    input  logic       sync_pll_sub,
    output logic [1:0] src_o,
    output logic [2:0] ratio_o,
    output logic       stat_no_pll_o,
    output logic       stat_no_sub_o,
    output logic       wait_err_o
);
    cfg_t cfg_in, cfg_q;
    src_e want, src_q;
    logic wsel_ok, tmr_load, tmr_done;

    assign cfg_in = '{pll_off: cfg_pll_off, sub_off: cfg_sub_off,
                      ratio: cfg_ratio, wsel: cfg_wait_sel};

    ckm_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wr_cfg(cfg_in),
        .cfg_q(cfg_q), .want(want), .wsel_ok(wsel_ok)
    );

    ckm_stab_timer #(.BASE_LOG2(WAIT_BASE_LOG2)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .wsel(cfg_q.wsel), .done(tmr_done)
    );

    ckm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .want(want), .wsel_ok(wsel_ok),
        .ratio_sel(cfg_q.ratio), .tmr_done(tmr_done),
        .sync_pm(sync_pll_main), .sync_ms(sync_main_sub), .sync_ps(sync_pll_sub),
        .tmr_load(tmr_load), .src_q(src_q), .ratio_q(ratio_o),
        .no_pll_q(stat_no_pll_o), .no_sub_q(stat_no_sub_o), .err_q(wait_err_o)
    );

    assign src_o = src_q;
endmodule

// File: rtl/ckmode_ctrl_chk.sv
`timescale 1ns/1ps
module ckmode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_pll_main,
    input logic       sync_main_sub,
    input logic       sync_pll_sub,
    input logic       tmr_done,
    input logic [1:0] src_o,
    input logic [2:0] ratio_o,
    input logic       stat_no_pll_o,
    input logic       stat_no_sub_o,
    input logic       wait_err_o
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (src_o == 2'd0 && stat_no_pll_o && stat_no_sub_o && ratio_o == 3'd0 && !wait_err_o)); // R1

    AST_PLL_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) != 2'd1 && src_o == 2'd1) |-> $past(tmr_done)); // R3

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) == 2'd1 && src_o == 2'd1) |-> $stable(ratio_o)); // R4

    AST_PLL_TO_MAIN_SYNC: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) == 2'd1 && src_o == 2'd0) |-> $past(sync_pll_main)); // R5

    AST_MAIN_TO_SUB_SYNC: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) == 2'd0 && src_o == 2'd2) |-> $past(sync_main_sub)); // R6

    AST_PLL_TO_SUB_SYNC: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) == 2'd1 && src_o == 2'd2) |-> $past(sync_pll_sub)); // R7

    AST_MAIN_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        ($past(src_o) == 2'd2 && src_o == 2'd0) |-> $past(tmr_done)); // R8

    AST_ERR_ONLY_SUB: assert property (@(posedge clk) disable iff (rst)
        wait_err_o |-> src_o == 2'd2); // R9

    AST_STATUS_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(stat_no_pll_o) || !$stable(stat_no_sub_o)) |-> !$stable(src_o)); // R10

    AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        src_o != 2'd3); // R2
endmodule

bind ckmode_ctrl ckmode_ctrl_chk u_chk (
    .clk(clk), .rst(rst),
    .sync_pll_main(sync_pll_main), .sync_main_sub(sync_main_sub), .sync_pll_sub(sync_pll_sub),
    .tmr_done(tmr_done), .src_o(src_o), .ratio_o(ratio_o),
    .stat_no_pll_o(stat_no_pll_o), .stat_no_sub_o(stat_no_sub_o), .wait_err_o(wait_err_o)
);

// File: tb/ckmode_ctrl_tb.sv
`timescale 1ns/1ps
module ckmode_ctrl_tb;
    localparam int BASE = 3;
    localparam int SMAIN = 0, SPLL = 1, SSUB = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_wr = 1'b0, cfg_pll_off = 1'b1, cfg_sub_off = 1'b1;
    logic [2:0] cfg_ratio = '0;
    logic [1:0] cfg_wait_sel = '0;
    logic s_pm = 1'b0, s_ms = 1'b0, s_ps = 1'b0;
    logic [1:0] src;
    logic [2:0] ratio;
    logic no_pll, no_sub, werr;
    int n_chk = 0, n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    ckmode_ctrl #(.WAIT_BASE_LOG2(BASE)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pll_off(cfg_pll_off),
        .cfg_sub_off(cfg_sub_off), .cfg_ratio(cfg_ratio), .cfg_wait_sel(cfg_wait_sel),
        .sync_pll_main(s_pm), .sync_main_sub(s_ms), .sync_pll_sub(s_ps),
        .src_o(src), .ratio_o(ratio), .stat_no_pll_o(no_pll),
        .stat_no_sub_o(no_sub), .wait_err_o(werr)
    );

    function automatic int wlen(input int w);
        return 1 << (BASE + w);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic tickn(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic po, input logic so, input logic [2:0] r, input logic [1:0] w);
        cfg_wr = 1'b1; cfg_pll_off = po; cfg_sub_off = so; cfg_ratio = r; cfg_wait_sel = w;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        s_pm = (which == 0); s_ms = (which == 1); s_ps = (which == 2);
        tick();
        s_pm = 1'b0; s_ms = 1'b0; s_ps = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tickn(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 src", src, SMAIN); chk("R1 no_pll", no_pll, 1); chk("R1 no_sub", no_sub, 1);
        chk("R1 ratio", ratio, 0); chk("R1 err", werr, 0);

        // R3 R4 R5 R10: sweep every wait select and ratio code from main
        for (int w = 0; w < 4; w++) begin
            for (int c = 0; c < 8; c++) begin
                int exp_r;
                exp_r = (c >= 4) ? 4 : c;
                wr(1'b0, 1'b1, 3'(c), 2'(w));
                tickn(wlen(w));
                chk("R3 before end", src, SMAIN); chk("R10 no_pll in wait", no_pll, 1);
                tick();
                chk("R3 after end", src, SPLL); chk("R4 ratio", ratio, exp_r);
                chk("R10 no_pll", no_pll, 0); chk("R10 no_sub", no_sub, 1);
                wr(1'b0, 1'b1, ~3'(c), 2'(w));
                tickn(2);
                chk("R4 ratio hold", ratio, exp_r);
                wr(1'b1, 1'b1, 3'(c), 2'(w));
                tickn(3);
                chk("R5 hold", src, SPLL);
                pulse(1); pulse(2);
                chk("R5 wrong sync", src, SPLL); chk("R10 no_pll hold", no_pll, 0);
                pulse(0);
                chk("R5 back main", src, SMAIN); chk("R10 no_pll back", no_pll, 1);
            end
        end

        // R2 R6: sub request overrides PLL select
        wr(1'b0, 1'b0, 3'd0, 2'd0);
        tickn(wlen(3) + 4);
        chk("R2 no pll wait", src, SMAIN);
        pulse(0);
        chk("R6 wrong sync", src, SMAIN);
        pulse(1);
        chk("R6 to sub", src, SSUB); chk("R10 no_sub", no_sub, 0); chk("R2 no_pll", no_pll, 1);

        // R9: short waits refused
        wr(1'b0, 1'b1, 3'd3, 2'd0);
        tickn(2);
        chk("R9 err ws0", werr, 1); chk("R9 stay sub", src, SSUB);
        wr(1'b0, 1'b1, 3'd3, 2'd1);
        tickn(2);
        chk("R9 err ws1", werr, 1);
        tickn(wlen(1) + 2);
        chk("R9 still sub", src, SSUB);
        wr(1'b0, 1'b1, 3'd3, 2'd2);
        tick();
        chk("R9 err clear", werr, 0);
        tickn(wlen(2) - 1);
        chk("R9 wait sub", src, SSUB); chk("R10 no_sub in wait", no_sub, 0);
        tick();
        chk("R9 to pll", src, SPLL); chk("R9 ratio", ratio, 3); chk("R10 no_sub off", no_sub, 1);

        // R7: PLL to sub
        wr(1'b0, 1'b0, 3'd3, 2'd2);
        tick();
        pulse(0);
        chk("R7 wrong pm", src, SPLL);
        pulse(1);
        chk("R7 wrong ms", src, SPLL);
        pulse(2);
        chk("R7 to sub", src, SSUB); chk("R7 no_pll", no_pll, 1);

        // R8 R12: sub to main, repeated waits
        foreach (int_wsel_list[k]) begin end
        for (int k = 0; k < 4; k++) begin
            int w;
            w = (k < 2) ? 3 : k - 2;
            wr(1'b1, 1'b1, 3'd0, 2'(w));
            tickn(wlen(w));
            chk("R12 wait length", src, SSUB);
            tick();
            chk("R8 to main", src, SMAIN); chk("R8 no_sub", no_sub, 1);
            wr(1'b1, 1'b0, 3'd0, 2'(w));
            tick();
            pulse(1);
            chk("R8 back sub", src, SSUB);
        end

        // R11: write latched during a wait
        wr(1'b1, 1'b1, 3'd0, 2'd0);
        tickn(wlen(0) + 1);
        chk("R11 main", src, SMAIN);
        wr(1'b0, 1'b1, 3'd5, 2'd0);
        tickn(3);
        wr(1'b1, 1'b1, 3'd5, 2'd0);
        tickn(4);
        chk("R11 still waiting", src, SMAIN);
        tick();
        chk("R11 pll reached", src, SPLL); chk("R11 ratio", ratio, 4);
        tickn(2);
        chk("R11 hold pll", src, SPLL);
        pulse(0);
        chk("R11 then main", src, SMAIN);

        // R11: write latched during a sync hold
        wr(1'b1, 1'b0, 3'd0, 2'd0);
        tick();
        wr(1'b1, 1'b1, 3'd0, 2'd0);
        pulse(1);
        chk("R11 sub first", src, SSUB);
        tickn(wlen(0));
        chk("R11 sub wait", src, SSUB);
        tick();
        chk("R11 main after", src, SMAIN);

        finish_run();
    end

    int int_wsel_list[1];
endmodule